// File: doc/BRIEF.md
# Pixel-Clock Divider Search Engine

This block turns a requested pixel-clock frequency, given in hertz, into a programming word for a fractional frequency synthesizer. A start pulse captures the request and a 2-bit clock-select code. The engine first chooses a post-divider code from fixed frequency thresholds and scales the target up by it. It then sweeps the synthesizer numerator N over a bounded range. For each N it estimates a central denominator, clamps the estimate to a legal window, and scores up to seven denominators M around it. The pair with the smallest error wins.

All arithmetic runs one step at a time. A single restoring divider that yields one quotient bit per clock is shared by every division: target/N, the denominator estimate, reference/M for each candidate, and the final VCO frequency. When the sweep ends, the VCO frequency of the winning pair is looked up in a table of 16 ascending limits to get a range index. The range index, post-divider, N, M and select are packed into a 24-bit word. A one-cycle done pulse then marks the new word. The reference frequency is 28 636 360 Hz. The denominator window is [14, 71], which comes from max(3, ref/2 MHz) and min(129, ref/400 kHz).

Top module: `pclk_div_search`

## Requirements
- R1: After an accepted start, done_o is high for exactly one cycle when the search ends. In that cycle word_o takes the new result, and word_o changes at no other time.
- R2: The post-divider code in word_o[9:8] is 3 below 12 500 000 Hz, 2 below 25 000 000 Hz, 1 below 50 000 000 Hz and 0 otherwise. The search target is the request shifted left by that code.
- R3: The numerator is swept upward over N_MIN..N_MAX (4..130 by default). word_o[17:11] holds N−3 of the winner.
- R4: For each N, the denominator estimate is floor(ref / floor(target/N)), clamped to [14, 71]. An intermediate quotient of zero gives the estimate 71.
- R5: The candidates are estimate−3 through estimate+3 in ascending order, and those outside [14, 71] are skipped. word_o[7:1] holds M−2 of the winner.
- R6: The error is |floor(ref/M)·N − target|. A candidate replaces the best so far when its error is less than or equal to the best, so on a tie the later candidate wins. At each start the best error is set to all ones and the best N and M to 1.
- R7: word_o[21:18] is the smallest i in 0..14 for which table entry i+1 is at least 2·floor(floor(ref/2)·N/M). If no such i exists it is 15. The default table entry i is 40 MHz + i·15 MHz.
- R8: word_o[23:22] is the select code captured at start. Bits 10 and 0 are zero.
- R9: A start pulse while a search runs is ignored. The running search finishes with its own request and gives one done pulse.
- R10: After reset, done_o is 0 and word_o is 0.
- R11: Every quotient is floor(dividend/divisor) from a restoring divider. A zero divisor gives a quotient of all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| freq_i | input | 32 | Requested frequency in Hz |
| sel_i | input | 2 | Clock-select code packed into the word |
| done_o | output | 1 | One-cycle pulse when word_o is updated |
| word_o | output | 24 | Packed synthesizer programming word |

## Verification
A corrupted best error, a bad best pair or a wrong sweep counter does not show up right away. It appears only at the single done pulse of that search, as a wrong N, M or range field, one full sweep after the fault. The bench therefore checks each packed field on its own against a model that runs the same sweep. It uses a narrow-sweep instance to cover many threshold and clamp cases cheaply. A lost or doubled done pulse, or a word that drifts between searches, is visible within one cycle of the pulse. The bench samples the word again on the following cycle.

// File: rtl/pds_pkg.sv
`timescale 1ns/1ps
package pds_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUO_WAIT,
        ST_EST_WAIT,
        ST_PICK,
        ST_CAND_WAIT,
        ST_VCO_WAIT
    } srch_state_e;

    typedef logic [15:0][31:0] vco_tab_t;

    // Ascending VCO limits: 40 MHz plus 15 MHz per step.
    function automatic vco_tab_t default_vco_tab();
        vco_tab_t t;
        for (int i = 0; i < 16; i++) begin
            t[i] = 32'(40_000_000 + i * 15_000_000);
        end
        return t;
    endfunction

endpackage

// File: rtl/pds_divider.sv
`timescale 1ns/1ps
module pds_divider #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic         done_o,
    output logic [W-1:0] quot_o
);
    localparam int unsigned CW = $clog2(W + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [W-1:0]  num_sh;
        logic [W-1:0]  num0;
        logic [W-1:0]  den;
        logic [W-1:0]  rem;
        logic [W-1:0]  quot;
        logic          done;
    } div_t;

    div_t q, d;
    logic [W:0]   rem_sh;
    logic         ge;
    logic [W-1:0] sub;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        rem_sh = {q.rem, q.num_sh[W-1]};
        ge     = rem_sh >= {1'b0, q.den};
        sub    = rem_sh[W-1:0] - q.den;
        if (go_i) begin
            d.cnt    = CW'(W);
            d.num_sh = num_i;
            d.num0   = num_i;
            d.den    = den_i;
            d.rem    = '0;
            d.quot   = '0;
        end else if (q.cnt != '0) begin
            d.rem    = ge ? sub : rem_sh[W-1:0];
            d.quot   = {q.quot[W-2:0], ge};
            d.num_sh = q.num_sh << 1;
            d.cnt    = q.cnt - CW'(1);
            if (q.cnt == CW'(1)) begin
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign quot_o = q.quot;

    // R11: quotient and remainder reconstruct the dividend
    assert_div_exact_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.den != '0) |->
        ((2*W)'(q.quot) * (2*W)'(q.den) + (2*W)'(q.rem) == (2*W)'(q.num0)) && (q.rem < q.den));

    // R11: zero divisor saturates the quotient
    assert_div_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.den == '0) |-> (q.quot == '1));

endmodule

// File: rtl/pds_postdiv.sv
`timescale 1ns/1ps
module pds_postdiv #(
    parameter int unsigned FLOOR_HZ = 50_000_000
) (
    input  logic [31:0] freq_i,
    output logic [1:0]  code_o,
    output logic [31:0] target_o
);
    localparam logic [31:0] LIM1 = 32'(FLOOR_HZ);
    localparam logic [31:0] LIM2 = 32'(FLOOR_HZ / 2);
    localparam logic [31:0] LIM3 = 32'(FLOOR_HZ / 4);

    always_comb begin
        code_o = 2'd0;
        if (freq_i < LIM1) code_o = 2'd1;
        if (freq_i < LIM2) code_o = 2'd2;
        if (freq_i < LIM3) code_o = 2'd3;
        target_o = freq_i << code_o;
    end

endmodule

// File: rtl/pds_range_sel.sv
`timescale 1ns/1ps
module pds_range_sel #(
    parameter pds_pkg::vco_tab_t TAB = pds_pkg::default_vco_tab()
) (
    input  logic [31:0] half_vco_i,
    output logic [3:0]  idx_o
);
    logic [32:0] vco;
    logic [14:0] hit;

    assign vco = {half_vco_i, 1'b0};

    for (genvar g = 0; g < 15; g++) begin : g_cmp
        assign hit[g] = {1'b0, TAB[g+1]} >= vco;
    end

    always_comb begin
        idx_o = 4'd15;
        for (int i = 14; i >= 0; i--) begin
            if (hit[i]) idx_o = 4'(i);
        end
    end

endmodule

// File: rtl/pclk_div_search.sv
`timescale 1ns/1ps
module pclk_div_search #(
    parameter int unsigned REF_HZ       = 28_636_360,
    parameter int unsigned VCO_FLOOR_HZ = 50_000_000,
    parameter int unsigned N_MIN        = 4,
    parameter int unsigned N_MAX        = 130,
    parameter int unsigned DEN_ABS_MIN  = 3,
    parameter int unsigned DEN_ABS_MAX  = 129,
    parameter int unsigned EST_LO_HZ    = 2_000_000,
    parameter int unsigned EST_HI_HZ    = 400_000,
    parameter int unsigned CAND_SPAN    = 3,
    parameter pds_pkg::vco_tab_t VCO_TAB = pds_pkg::default_vco_tab()
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [31:0] freq_i,
    input  logic [1:0]  sel_i,
    output logic        done_o,
    output logic [23:0] word_o
);
    import pds_pkg::*;

    localparam int unsigned DEN_MIN  = (REF_HZ / EST_LO_HZ > DEN_ABS_MIN) ? REF_HZ / EST_LO_HZ : DEN_ABS_MIN;
    localparam int unsigned DEN_MAX  = (REF_HZ / EST_HI_HZ < DEN_ABS_MAX) ? REF_HZ / EST_HI_HZ : DEN_ABS_MAX;
    localparam int unsigned NW       = $clog2(N_MAX + 2);
    localparam int unsigned MW       = $clog2(DEN_MAX + CAND_SPAN + 1);
    localparam int unsigned K_END    = 2 * CAND_SPAN + 1;
    localparam int unsigned KW       = $clog2(K_END + 1);
    localparam int unsigned FLD_W    = 7;
    localparam logic [31:0] HALF_REF = 32'(REF_HZ / 2);
    localparam logic [MW:0] M_LO     = (MW+1)'(DEN_MIN);
    localparam logic [MW:0] M_HI     = (MW+1)'(DEN_MAX);

    typedef struct packed {
        srch_state_e    st;
        logic [1:0]     sel;
        logic [1:0]     pcode;
        logic [31:0]    target;
        logic [NW-1:0]  n;
        logic [MW-1:0]  est;
        logic [KW-1:0]  k;
        logic [31:0]    best_err;
        logic [NW-1:0]  best_n;
        logic [MW-1:0]  best_m;
        logic           go;
        logic [31:0]    num;
        logic [31:0]    den;
        logic [23:0]    word;
        logic           done;
    } ctl_t;

    ctl_t q, d;

    logic        div_done;
    logic [31:0] div_quot;
    logic [1:0]  pd_code;
    logic [31:0] pd_target;
    logic [3:0]  rng_idx;

    pds_postdiv #(.FLOOR_HZ(VCO_FLOOR_HZ)) u_postdiv (
        .freq_i   (freq_i),
        .code_o   (pd_code),
        .target_o (pd_target)
    );

    pds_divider #(.W(32)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (q.go),
        .num_i  (q.num),
        .den_i  (q.den),
        .done_o (div_done),
        .quot_o (div_quot)
    );

    pds_range_sel #(.TAB(VCO_TAB)) u_range (
        .half_vco_i (div_quot),
        .idx_o      (rng_idx)
    );

    logic [MW:0]    m_try;
    logic [31:0]    prod;
    logic [31:0]    err;
    logic [MW-1:0]  est_c;
    logic [FLD_W-1:0] n_fld;
    logic [FLD_W-1:0] m_fld;

    always_comb begin
        m_try = {1'b0, q.est} + (MW+1)'(q.k) - (MW+1)'(CAND_SPAN);
        prod  = div_quot * 32'(q.n);
        err   = (prod >= q.target) ? (prod - q.target) : (q.target - prod);
        if (div_quot > 32'(DEN_MAX)) begin
            est_c = MW'(DEN_MAX);
        end else if (div_quot < 32'(DEN_MIN)) begin
            est_c = MW'(DEN_MIN);
        end else begin
            est_c = MW'(div_quot);
        end
        n_fld = FLD_W'(q.best_n) - FLD_W'(3);
        m_fld = FLD_W'(q.best_m) - FLD_W'(2);
    end

    always_comb begin
        d      = q;
        d.go   = 1'b0;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.sel      = sel_i;
                    d.pcode    = pd_code;
                    d.target   = pd_target;
                    d.best_err = '1;
                    d.best_n   = NW'(1);
                    d.best_m   = MW'(1);
                    d.n        = NW'(N_MIN);
                    d.num      = pd_target;
                    d.den      = 32'(N_MIN);
                    d.go       = 1'b1;
                    d.st       = ST_QUO_WAIT;
                end
            end
            ST_QUO_WAIT: begin
                if (div_done) begin
                    d.num = 32'(REF_HZ);
                    d.den = div_quot;
                    d.go  = 1'b1;
                    d.st  = ST_EST_WAIT;
                end
            end
            ST_EST_WAIT: begin
                if (div_done) begin
                    d.est = est_c;
                    d.k   = '0;
                    d.st  = ST_PICK;
                end
            end
            ST_PICK: begin
                if (q.k == KW'(K_END)) begin
                    if (q.n == NW'(N_MAX)) begin
                        d.num = HALF_REF * 32'(q.best_n);
                        d.den = 32'(q.best_m);
                        d.go  = 1'b1;
                        d.st  = ST_VCO_WAIT;
                    end else begin
                        d.n   = q.n + NW'(1);
                        d.num = q.target;
                        d.den = 32'(q.n + NW'(1));
                        d.go  = 1'b1;
                        d.st  = ST_QUO_WAIT;
                    end
                end else if (m_try >= M_LO && m_try <= M_HI) begin
                    d.num = 32'(REF_HZ);
                    d.den = 32'(m_try);
                    d.go  = 1'b1;
                    d.st  = ST_CAND_WAIT;
                end else begin
                    d.k = q.k + KW'(1);
                end
            end
            ST_CAND_WAIT: begin
                if (div_done) begin
                    if (err <= q.best_err) begin
                        d.best_err = err;
                        d.best_n   = q.n;
                        d.best_m   = MW'(q.den);
                    end
                    d.k  = q.k + KW'(1);
                    d.st = ST_PICK;
                end
            end
            ST_VCO_WAIT: begin
                if (div_done) begin
                    d.word = {q.sel, rng_idx, n_fld, 1'b0, q.pcode, m_fld, 1'b0};
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign word_o = q.word;

    assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    assert_word_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.word) |-> q.done);

    assert_n_in_sweep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |-> (q.n >= NW'(N_MIN) && q.n <= NW'(N_MAX)));

    assert_m_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_CAND_WAIT) |-> (q.den >= 32'(DEN_MIN) && q.den <= 32'(DEN_MAX)));

    assert_best_err_monotone_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> (q.best_err <= $past(q.best_err)));

    assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE && start_i) |=> ($stable(q.target) && $stable(q.sel) && $stable(q.pcode)));

endmodule

// File: tb/pclk_div_search_tb.sv
`timescale 1ns/1ps
module pclk_div_search_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        start_w = 1'b0, start_n = 1'b0;
    logic [31:0] freq_w = '0, freq_n = '0;
    logic [1:0]  sel_w = '0, sel_n = '0;
    logic        done_w, done_n;
    logic [23:0] word_w, word_n;

    int checks = 0;
    int failures = 0;

    pclk_div_search u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_w), .freq_i(freq_w),
        .sel_i(sel_w), .done_o(done_w), .word_o(word_w)
    );

    pclk_div_search #(.N_MAX(8)) u_dut_nw (
        .clk(clk), .rst_n(rst_n), .start_i(start_n), .freq_i(freq_n),
        .sel_i(sel_n), .done_o(done_n), .word_o(word_n)
    );

    localparam int NV = 8;
    localparam longint VEC_F [NV] = '{50_000_000, 49_999_999, 25_000_000, 24_999_999,
                                      12_500_000, 12_499_999, 0, 120_000_000};
    localparam int VEC_S [NV] = '{0, 1, 2, 3, 0, 1, 2, 3};
    localparam int VEC_P [NV] = '{0, 1, 1, 2, 2, 3, 3, 0};

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] model(input longint f, input int s, input int nmin, input int nmax);
        longint rf, tgt, best_e, bn, bm, q1, est, e, vco;
        int p, idx;
        rf = 28636360;
        p = 0;
        if (f < 50000000) p = 1;
        if (f < 25000000) p = 2;
        if (f < 12500000) p = 3;
        tgt = f << p;
        best_e = 64'd4294967295;
        bn = 1;
        bm = 1;
        for (int n = nmin; n <= nmax; n++) begin
            q1 = tgt / n;
            est = (q1 == 0) ? 64'd4294967295 : rf / q1;
            if (est > 71) est = 71;
            if (est < 14) est = 14;
            for (longint m = est - 3; m <= est + 3; m++) begin
                if (m >= 14 && m <= 71) begin
                    e = (rf / m) * n - tgt;
                    if (e < 0) e = -e;
                    if (e <= best_e) begin
                        best_e = e;
                        bn = n;
                        bm = m;
                    end
                end
            end
        end
        vco = ((rf / 2) * bn / bm) * 2;
        idx = 0;
        while (idx < 15 && (40000000 + (idx + 1) * 15000000) < vco) idx++;
        return 24'(((bn - 3) << 11) | ((bm - 2) << 1) | (longint'(p) << 8)
                   | (longint'(idx) << 18) | (longint'(s) << 22));
    endfunction

    task automatic launch(input bit wide, input logic [31:0] f, input logic [1:0] s);
        @(negedge clk);
        if (wide) begin start_w = 1'b1; freq_w = f; sel_w = s; end
        else begin start_n = 1'b1; freq_n = f; sel_n = s; end
        @(negedge clk);
        start_w = 1'b0;
        start_n = 1'b0;
    endtask

    task automatic wait_done(input bit wide, output logic [23:0] w);
        bit seen = 1'b0;
        while (!seen) begin
            @(negedge clk);
            seen = wide ? done_w : done_n;
        end
        w = wide ? word_w : word_n;
        @(negedge clk);
        chk("R1 done pulse width", wide ? done_w : done_n, 0);
        chk("R1 word held after pulse", wide ? word_w : word_n, w);
    endtask

    task automatic check_fields(input string pre, input logic [23:0] w, input logic [23:0] e,
                                input int p, input int s);
        chk({pre, " R2 post-divider code"}, w[9:8], p);
        chk({pre, " R8 select field"}, w[23:22], s);
        chk({pre, " R8 spare bits"}, {w[10], w[0]}, 0);
        chk({pre, " R3 numerator field"}, w[17:11], e[17:11]);
        chk({pre, " R5 denominator field"}, w[7:1], e[7:1]);
        chk({pre, " R7 range index"}, w[21:18], e[21:18]);
        chk({pre, " R4 R6 R11 full word"}, w, e);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [23:0] w;
        int extra;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 done after reset", done_w, 0);
        chk("R10 word after reset", word_w, 0);
        chk("R10 narrow done after reset", done_n, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 word idle after release", word_n, 0);

        // Vector table on the narrow-sweep instance
        for (int i = 0; i < NV; i++) begin
            launch(1'b0, 32'(VEC_F[i]), 2'(VEC_S[i]));
            wait_done(1'b0, w);
            check_fields($sformatf("vec%0d", i), w, model(VEC_F[i], VEC_S[i], 4, 8),
                         VEC_P[i], VEC_S[i]);
        end

        // Full sweep, with a start pulse during the search (R9)
        launch(1'b1, 32'd65_000_000, 2'd1);
        repeat (200) @(negedge clk);
        launch(1'b1, 32'd20_000_000, 2'd3);
        wait_done(1'b1, w);
        check_fields("full65 R9", w, model(65000000, 1, 4, 130), 0, 1);
        extra = 0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (done_w) extra++;
        end
        chk("R9 no second done pulse", extra, 0);
        chk("R1 word stable while idle", word_w, w);

        // Full sweep at the lowest post-divider band
        launch(1'b1, 32'd10_000_000, 2'd2);
        wait_done(1'b1, w);
        check_fields("full10", w, model(10000000, 2, 4, 130), 3, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule